// File: doc/BRIEF.md
# Spill-Synchronized Acquisition Trigger Generator

This block sits in the clock-and-control logic of a detector readout system and turns external accelerator timing into acquisition gates for the front-end electronics. A spill announcement (the pre-trigger) arrives long before the beam. It carries a 16-bit spill number, which the block captures. It also reserves the block for the coming spill, so no other gate can start. The later beam trigger opens the acquisition window after a programmable delay. The window length is also programmable, so that the gate covers the few microseconds when particles arrive.

Between spills the block can run a periodic self-trigger, for example to sample detector noise. Every gate is followed by a fixed conversion-and-readout holdoff. A separate minimum spacing between gate openings caps the acquisition rate; at a 50 MHz clock the defaults give a 1 ms holdoff and a 100 Hz ceiling. A trigger that arrives when it cannot be served is dropped and counted in a saturating counter. All trigger inputs are synchronous to the clock and act on their rising edge.

Top module: `spill_acq_trigger`

## Requirements
- R1: While `rst` is high and after its release, `acq_gate`, `gate_src` and `busy` are 0, `spill_num` is 0 and `missed_cnt` is 0.
- R2: A rising edge of `pre_trig` while idle stores `spill_in` into `spill_num` and sets `busy` from the next cycle. `spill_num` changes only when a pre-trigger is accepted.
- R3: After an accepted pre-trigger, a rising edge of `beam_trig` sampled at clock edge N opens `acq_gate` at edge N+`cfg_delay`+1, with `gate_src`=1 (1 = beam, 0 = periodic).
- R4: Every gate stays high for `cfg_width` cycles, or for one cycle when `cfg_width` is 0.
- R5: After a gate closes, `busy` stays high and no gate opens for HOLD_CYC cycles. Then `busy` returns to 0.
- R6: Two gate openings are at least RATE_CYC cycles apart. A beam gate whose delay expires too early waits and opens on the first allowed cycle.
- R7: With `cfg_periodic_en`=1 and `cfg_period`=P>0, a tick occurs every P cycles, counted from the cycle in which the enable is first sampled high. A tick opens a gate with `gate_src`=0 only when the block is idle and the spacing of R6 allows it; other ticks are skipped. With P=0 no periodic gate occurs.
- R8: From the acceptance of a pre-trigger until the holdoff after its beam gate ends, no periodic gate opens. A pre-trigger and a tick in the same cycle resolve to the pre-trigger.
- R9: A pre-trigger edge while not idle, or a beam-trigger edge without a pending pre-trigger, is dropped. A dropped pre-trigger leaves `spill_num` unchanged. Each cycle with a drop adds 1 to `missed_cnt`, which saturates at 2^MISS_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_trig | input | 1 | Spill announcement, acts on its rising edge |
| beam_trig | input | 1 | Beam arrival trigger, acts on its rising edge |
| spill_in | input | 16 | Spill number that comes with the pre-trigger |
| cfg_delay | input | DLY_W | Beam-to-gate delay in cycles |
| cfg_width | input | WID_W | Gate length in cycles (0 acts as 1) |
| cfg_period | input | PER_W | Periodic tick interval in cycles (0 disables) |
| cfg_periodic_en | input | 1 | Enables periodic self-triggering |
| acq_gate | output | 1 | Acquisition gate |
| gate_src | output | 1 | Source of the current gate: 1 beam, 0 periodic |
| busy | output | 1 | High while a spill is pending, a gate is open or holdoff runs |
| spill_num | output | 16 | Spill number of the last accepted pre-trigger |
| missed_cnt | output | MISS_W | Saturating count of dropped triggers |

## Verification
Beam gates are tried with a nonzero delay and width and with both set to zero. Together these separate a wrong delay offset from a wrong width and show the zero-width floor. A beam trigger issued just after a short gate exposes whether the spacing limit defers the gate or lets it through. Periodic runs use a long period, where every tick fires, and a short period, where only every third tick fires because of the spacing limit. A zero period must give no gate at all. A run that combines a spill with periodic mode shows that ticks stay blocked from the pre-trigger through the holdoff. Stray and repeated triggers check the drop counter, its saturation and that the latched spill number is preserved.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int SPILL_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_DELAY,
    ST_GATE,
    ST_HOLD
  } acq_state_t;
endpackage

// File: rtl/trig_edge.sv
module trig_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= din;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      assign rise[gi] = din[gi] & ~din_q[gi];
    end
  endgenerate
endmodule

// File: rtl/trig_periodic.sv
module trig_periodic #(
  parameter int PER_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] pcnt;
  logic             run;

  assign run  = en && (period != '0);
  assign tick = run && (pcnt >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)               pcnt <= '0;
    else if (!run || tick) pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end

  // R7: ticks with a period above one are never back to back
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && period > 1 && $stable(period)) |=> !tick);
endmodule

// File: rtl/trig_sat_counter.sv
module trig_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  // R9: saturation holds the top value
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R9: the count never goes down outside reset
  assert_no_decrease_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/spill_acq_trigger.sv
module spill_acq_trigger
  import trig_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int WID_W    = 12,
  parameter int PER_W    = 26,
  parameter int HOLD_CYC = 50000,
  parameter int RATE_CYC = 500000,
  parameter int MISS_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pre_trig,
  input  logic               beam_trig,
  input  logic [SPILL_W-1:0] spill_in,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic [WID_W-1:0]   cfg_width,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic               cfg_periodic_en,
  output logic               acq_gate,
  output logic               gate_src,
  output logic               busy,
  output logic [SPILL_W-1:0] spill_num,
  output logic [MISS_W-1:0]  missed_cnt
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int RATE_W = $clog2(RATE_CYC + 1);
  localparam int DW_MAX = (DLY_W > WID_W) ? DLY_W : WID_W;
  localparam int TMR_W  = (DW_MAX > HOLD_W) ? DW_MAX : HOLD_W;
  localparam logic [TMR_W-1:0]  HOLD_LOAD = TMR_W'(HOLD_CYC - 1);
  localparam logic [RATE_W-1:0] RATE_LOAD = RATE_W'(RATE_CYC - 1);

  // ---------------- trigger edges and periodic source ----------------
  logic [1:0] trig_rise;
  logic       pre_rise, beam_rise, tick;

  trig_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({beam_trig, pre_trig}),
    .rise (trig_rise)
  );
  assign pre_rise  = trig_rise[0];
  assign beam_rise = trig_rise[1];

  trig_periodic #(.PER_W(PER_W)) u_periodic (
    .clk    (clk),
    .rst    (rst),
    .en     (cfg_periodic_en),
    .period (cfg_period),
    .tick   (tick)
  );

  // ---------------- rate limiter ----------------
  logic [RATE_W-1:0] rate_cnt;
  logic              rate_ok;
  logic              gate_open;

  assign rate_ok = (rate_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)             rate_cnt <= '0;
    else if (gate_open)  rate_cnt <= RATE_LOAD;
    else if (!rate_ok)   rate_cnt <= rate_cnt - 1'b1;
  end

  // ---------------- sequencer ----------------
  acq_state_t       state, state_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic [TMR_W-1:0] width_load;
  logic             src_q, src_n;
  logic             pre_acc, drop_pre, drop_beam, miss_inc;

  assign width_load = (cfg_width == '0) ? '0 : TMR_W'(cfg_width - 1'b1);

  always_comb begin
    state_n   = state;
    tmr_n     = tmr;
    src_n     = src_q;
    pre_acc   = 1'b0;
    gate_open = 1'b0;
    case (state)
      ST_IDLE: begin
        if (pre_rise) begin
          state_n = ST_ARMED;
          pre_acc = 1'b1;
        end else if (tick && rate_ok) begin
          state_n   = ST_GATE;
          tmr_n     = width_load;
          src_n     = 1'b0;
          gate_open = 1'b1;
        end
      end
      ST_ARMED: begin
        if (beam_rise) begin
          state_n = ST_DELAY;
          tmr_n   = TMR_W'(cfg_delay);
        end
      end
      ST_DELAY: begin
        if (tmr != '0) begin
          tmr_n = tmr - 1'b1;
        end else if (rate_ok) begin
          state_n   = ST_GATE;
          tmr_n     = width_load;
          src_n     = 1'b1;
          gate_open = 1'b1;
        end
      end
      ST_GATE: begin
        if (tmr == '0) begin
          state_n = ST_HOLD;
          tmr_n   = HOLD_LOAD;
        end else begin
          tmr_n = tmr - 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr == '0) state_n = ST_IDLE;
        else           tmr_n   = tmr - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign drop_pre  = pre_rise  && (state != ST_IDLE);
  assign drop_beam = beam_rise && (state != ST_ARMED);
  assign miss_inc  = drop_pre || drop_beam;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      src_q     <= 1'b0;
      acq_gate  <= 1'b0;
      gate_src  <= 1'b0;
      busy      <= 1'b0;
      spill_num <= '0;
    end else begin
      state    <= state_n;
      tmr      <= tmr_n;
      src_q    <= src_n;
      acq_gate <= (state_n == ST_GATE);
      gate_src <= src_n;
      busy     <= (state_n != ST_IDLE);
      if (pre_acc) spill_num <= spill_in;
    end
  end

  trig_sat_counter #(.W(MISS_W)) u_missed (
    .clk (clk),
    .rst (rst),
    .inc (miss_inc),
    .cnt (missed_cnt)
  );

  // ---------------- assertions ----------------
  // R5: an open gate always shows as busy
  assert_gate_busy_R5: assert property (@(posedge clk) disable iff (rst)
    acq_gate |-> busy);

  // R2: spill number only moves on an accepted pre-trigger
  assert_spill_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !pre_acc |=> $stable(spill_num));

  // R6: a gate opens only once the spacing window has run out
  assert_rate_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_gate) |-> ($past(rate_cnt) == '0));

  // R8: no periodic gate while a spill is pending
  assert_spill_blocks_periodic_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED || state == ST_DELAY) |=> !(acq_gate && !gate_src));

  // R5: holdoff never goes straight into a gate
  assert_hold_no_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> !$rose(acq_gate));
endmodule

// File: tb/test_spill_acq_trigger.sv
module test_spill_acq_trigger;
  localparam int DLY_W = 8, WID_W = 8, PER_W = 8, HOLD_CYC = 10, RATE_CYC = 30, MISS_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pre_trig = 1'b0, beam_trig = 1'b0;
  logic [15:0]       spill_in = '0;
  logic [DLY_W-1:0]  cfg_delay = '0;
  logic [WID_W-1:0]  cfg_width = '0;
  logic [PER_W-1:0]  cfg_period = '0;
  logic              cfg_periodic_en = 1'b0;
  logic              acq_gate, gate_src, busy;
  logic [15:0]       spill_num;
  logic [MISS_W-1:0] missed_cnt;

  spill_acq_trigger #(
    .DLY_W(DLY_W), .WID_W(WID_W), .PER_W(PER_W),
    .HOLD_CYC(HOLD_CYC), .RATE_CYC(RATE_CYC), .MISS_W(MISS_W)
  ) i_spill_acq_trigger (
    .clk(clk), .rst(rst), .pre_trig(pre_trig), .beam_trig(beam_trig),
    .spill_in(spill_in), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
    .cfg_period(cfg_period), .cfg_periodic_en(cfg_periodic_en),
    .acq_gate(acq_gate), .gate_src(gate_src), .busy(busy),
    .spill_num(spill_num), .missed_cnt(missed_cnt)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // scoreboard
  typedef struct {
    int        start;
    int        width;
    bit        beam;
    logic [15:0] spill;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;
  bit   gate_d = 0;
  int   wcnt = 0;

  task automatic push_gate(input int start, input int width, input bit beam, input logic [15:0] sp);
    exp_t e;
    e.start = start; e.width = width; e.beam = beam; e.spill = sp;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (acq_gate && !gate_d) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected gate: actual start %0d expected none", cyc);
          cur.width = -1;
        end else begin
          cur = exp_q.pop_front();
          chk("R3/R6/R7 gate start cycle", cyc, cur.start);
          chk("R3/R7 gate source", int'(gate_src), int'(cur.beam));
          chk("R2 spill number at gate", int'(spill_num), int'(cur.spill));
        end
        wcnt = 1;
      end else if (acq_gate) begin
        wcnt++;
      end else if (gate_d && cur.width >= 0) begin
        chk("R4 gate width", wcnt, cur.width);
      end
      gate_d = acq_gate;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int b, g;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 gate in reset", int'(acq_gate), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 spill in reset", int'(spill_num), 0);
    chk("R1 missed in reset", int'(missed_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after release", int'(busy), 0);

    // R9: beam without pre-trigger is dropped
    b = cyc + 2;
    wait_until(b); beam_trig = 1;
    wait_until(b + 1); chk("R9 stray beam counted", int'(missed_cnt), 1);
    wait_until(b + 2); beam_trig = 0;

    // R2/R3/R5/R9: spill with delay 3, width 5
    b = cyc + 5; cfg_delay = 3; cfg_width = 5;
    wait_until(b); pre_trig = 1; spill_in = 16'hA5C3;
    wait_until(b + 1);
    chk("R2 busy after pre", int'(busy), 1);
    chk("R2 spill latched", int'(spill_num), 16'hA5C3);
    wait_until(b + 2); pre_trig = 0;
    wait_until(b + 5); pre_trig = 1; spill_in = 16'h1111;
    wait_until(b + 6);
    chk("R9 repeated pre counted", int'(missed_cnt), 2);
    chk("R9 dropped pre keeps spill", int'(spill_num), 16'hA5C3);
    wait_until(b + 7); pre_trig = 0;
    push_gate(b + 25, 5, 1, 16'hA5C3);
    wait_until(b + 20); beam_trig = 1;
    wait_until(b + 22); beam_trig = 0;
    wait_until(b + 27); beam_trig = 1;
    wait_until(b + 28); chk("R9 beam during gate counted", int'(missed_cnt), 3);
    wait_until(b + 29); beam_trig = 0;
    wait_until(b + 39); chk("R5 busy in holdoff", int'(busy), 1);
    wait_until(b + 40); chk("R5 busy clears after holdoff", int'(busy), 0);
    wait_until(b + 45); beam_trig = 1;
    wait_until(b + 46); chk("R9 counter saturates", int'(missed_cnt), 3);
    wait_until(b + 47); beam_trig = 0;

    // R3/R4: delay 0, width 0
    b = cyc + 50; cfg_delay = 0; cfg_width = 0;
    wait_until(b); pre_trig = 1; spill_in = 16'h0001;
    wait_until(b + 2); pre_trig = 0;
    push_gate(b + 12, 1, 1, 16'h0001);
    wait_until(b + 10); beam_trig = 1;
    wait_until(b + 12); beam_trig = 0;

    // R6: beam gate deferred by spacing limit
    g = b + 12; cfg_width = 2;
    wait_until(g + 12); pre_trig = 1; spill_in = 16'h2222;
    wait_until(g + 14); pre_trig = 0; beam_trig = 1;
    wait_until(g + 16); beam_trig = 0;
    push_gate(g + 30, 2, 1, 16'h2222);
    wait_until(g + 20); chk("R6 busy while deferred", int'(busy), 1);
    chk("R6 no gate while deferred", int'(acq_gate), 0);
    wait_until(g + 60);

    // R7: long period, every tick fires
    b = cyc + 5; cfg_width = 5; cfg_period = 40;
    wait_until(b); cfg_periodic_en = 1;
    push_gate(b + 40, 5, 0, 16'h2222);
    push_gate(b + 80, 5, 0, 16'h2222);
    push_gate(b + 120, 5, 0, 16'h2222);
    wait_until(b + 125); cfg_periodic_en = 0;
    wait_until(b + 200);

    // R6/R7: short period limited by spacing
    b = cyc + 5; cfg_period = 12;
    wait_until(b); cfg_periodic_en = 1;
    push_gate(b + 12, 5, 0, 16'h2222);
    push_gate(b + 48, 5, 0, 16'h2222);
    push_gate(b + 84, 5, 0, 16'h2222);
    wait_until(b + 90); cfg_periodic_en = 0;
    wait_until(b + 150);

    // R8: spill blocks periodic ticks until holdoff ends
    b = cyc + 5; cfg_period = 40; cfg_delay = 3;
    wait_until(b); cfg_periodic_en = 1;
    wait_until(b + 5); pre_trig = 1; spill_in = 16'hBEEF;
    wait_until(b + 7); pre_trig = 0;
    push_gate(b + 65, 5, 1, 16'hBEEF);
    push_gate(b + 120, 5, 0, 16'hBEEF);
    wait_until(b + 41); chk("R8 no tick gate while armed", int'(acq_gate), 0);
    wait_until(b + 60); beam_trig = 1;
    wait_until(b + 62); beam_trig = 0;
    wait_until(b + 81); chk("R8 no tick gate after holdoff edge", int'(acq_gate), 0);
    wait_until(b + 126); cfg_periodic_en = 0;
    wait_until(b + 200);

    // R7: zero period gives no gate
    b = cyc + 5; cfg_period = 0;
    wait_until(b); cfg_periodic_en = 1;
    wait_until(b + 100); cfg_periodic_en = 0;
    chk("R7 all expected gates seen", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule